// File: doc/BRIEF.md
# Pointer Address Generator for Indirect and Stack Accesses

This block forms data-memory addresses for a small 8-bit core. It serves indirect loads and stores through one of three 16-bit pointers, and it serves push and pop through a stack pointer that it holds itself. The register file keeps the three pointers as byte pairs: X is r27:r26, Y is r29:r28 and Z is r31:r30, with the high byte in the odd register. The decoder presents the selected pair on `ptr_in`. When an access changes its pointer, the block returns the new value on a write-back port.

Each request is accepted in one cycle while the block is idle. The single access cycle follows it, with `busy` high, the address on `mem_addr` and one strobe asserted. An operation therefore takes two cycles. A pointer access can leave the pointer unchanged (plain mode), use it and then step it up (post-increment), step it down first and then use it (pre-decrement), or add an unsigned 6-bit offset without changing it (displacement, Y and Z only). For the stack, push and pop update the pointer in opposite orders, so the two operations undo each other.

Top module: `ptr_agu`

## Requirements
- R1: After reset `busy`, `mem_rd`, `mem_wr` and `wb_en` are 0 and `sp` equals the parameter `SP_RESET` (default 0x045F).
- R2: Operation encoding on `op`: 0 load, 1 store, 2 push, 3 pop. A load or pop raises only `mem_rd` in its access cycle, and a store or push raises only `mem_wr`. The two strobes are never high together.
- R3: Timing: a request is accepted on a clock edge where `start` is high and `busy` is low. The next cycle is the only access cycle, with `busy` high. A `start` seen while `busy` is high is ignored.
- R4: Plain mode (`mode`=0): `mem_addr` equals `ptr_in` and `wb_en` stays 0.
- R5: Post-increment mode (`mode`=1): `mem_addr` equals `ptr_in`, and in the access cycle `wb_en` is 1 with `wb_val` = `ptr_in`+1.
- R6: Pre-decrement mode (`mode`=2): `mem_addr` and `wb_val` both equal `ptr_in`-1, with `wb_en` 1.
- R7: Displacement mode (`mode`=3): `mem_addr` = `ptr_in` + `disp`, where `disp` is unsigned from 0 to 63. `wb_en` stays 0.
- R8: Pointer select on `psel`: 0 X, 1 Y, 2 Z. `wb_sel` repeats the selected code during the access cycle. A request with `psel`=3, or displacement mode with X, is rejected: no strobe, no write-back, and `busy` stays low.
- R9: Push writes at the current `sp`, and `sp` is one lower from the access cycle onward.
- R10: Pop first raises `sp` by one and then reads at the raised value, so a pop undoes the preceding push.
- R11: All pointer and address arithmetic wraps modulo 2^16. Incrementing 0xFFFF gives 0x0000, decrementing 0x0000 gives 0xFFFF, and a displacement sum past 0xFFFF wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| op | input | 2 | Operation: 0 load, 1 store, 2 push, 3 pop |
| psel | input | 2 | Pointer: 0 X, 1 Y, 2 Z |
| mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| ptr_in | input | 16 | Current value of the selected pointer pair |
| busy | output | 1 | High during the access cycle |
| mem_addr | output | 16 | Data-memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer being written back |
| wb_val | output | 16 | New pointer value |
| sp | output | 16 | Stack pointer |

## Verification
The bench aims at the edges of the address arithmetic. It steps a pointer past 0xFFFF and below 0x0000, and it adds the largest offset close to the top of memory; a design that saturated or carried into a 17th bit would give the wrong address or write-back there. It pushes twice and then pops, which shows whether pop raises the stack pointer before reading: getting that order wrong makes the pop read a slot other than the one just written. It also sends rejected requests (displacement on X, pointer code 3) and holds `start` across the access cycle, since a design that took either would raise a stray strobe or step a pointer.

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int AW = 16,
  parameter int DISP_W = 6,
  parameter logic [AW-1:0] SP_RESET = 16'h045F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [1:0]        psel,
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     ptr_in,
  output logic              busy,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [AW-1:0]     wb_val,
  output logic [AW-1:0]     sp
);
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_PUSH = 2'd2, OP_POP = 2'd3;
  localparam logic [1:0] M_PLAIN = 2'd0, M_POST = 2'd1, M_PRE = 2'd2, M_DISP = 2'd3;
  localparam logic [1:0] P_X = 2'd0, P_NONE = 2'd3;

  wire is_stack = op[1];
  wire ptr_ok   = (psel != P_NONE) && !(mode == M_DISP && psel == P_X);
  wire accept   = start && !busy && (is_stack || ptr_ok);

  wire [AW-1:0] p_inc  = ptr_in + 1'b1;
  wire [AW-1:0] p_dec  = ptr_in - 1'b1;
  wire [AW-1:0] p_dsp  = ptr_in + AW'(disp);
  wire [AW-1:0] sp_dec = sp - 1'b1;
  wire [AW-1:0] sp_inc = sp + 1'b1;

  logic [AW-1:0] addr_n;
  always_comb begin
    if (is_stack)
      addr_n = (op == OP_PUSH) ? sp : sp_inc;
    else begin
      case (mode)
        M_PRE:   addr_n = p_dec;
        M_DISP:  addr_n = p_dsp;
        default: addr_n = ptr_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= 2'd0;
      wb_val   <= '0;
      mem_addr <= '0;
      sp       <= SP_RESET;
    end else begin
      busy   <= accept;
      mem_rd <= accept && (op == OP_LD || op == OP_POP);
      mem_wr <= accept && (op == OP_ST || op == OP_PUSH);
      wb_en  <= accept && !is_stack && (mode == M_POST || mode == M_PRE);
      if (accept) begin
        mem_addr <= addr_n;
        wb_sel   <= psel;
        wb_val   <= (mode == M_POST) ? p_inc : p_dec;
        if (op == OP_PUSH) sp <= sp_dec;
        if (op == OP_POP)  sp <= sp_inc;
      end
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_strobe_in_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || wb_en) |-> busy);
  assert_single_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_plain_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[1] && mode == M_PLAIN && psel != P_NONE)
      |=> (mem_addr == $past(ptr_in)) && !wb_en);
  assert_post_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[1] && mode == M_POST && psel != P_NONE)
      |=> (mem_addr == $past(ptr_in)) && wb_en && (wb_val == $past(ptr_in) + 1'b1));
  assert_pre_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[1] && mode == M_PRE && psel != P_NONE)
      |=> (mem_addr == $past(ptr_in) - 1'b1) && wb_en);
  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[1] && (psel == P_NONE || (mode == M_DISP && psel == P_X)))
      |=> !busy && !mem_rd && !mem_wr && !wb_en);
  assert_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_PUSH)
      |=> mem_wr && (mem_addr == $past(sp)) && (sp == $past(sp) - 1'b1));
  assert_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_POP)
      |=> mem_rd && (sp == $past(sp) + 1'b1) && (mem_addr == sp));
endmodule

// File: tb/ptr_agu_bench.sv
`timescale 1ns/1ps
module ptr_agu_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0, psel = 2'd0, mode = 2'd0;
  logic [5:0] disp = 6'd0;
  logic [15:0] ptr_in = 16'd0;
  logic busy, mem_rd, mem_wr, wb_en;
  logic [1:0] wb_sel;
  logic [15:0] mem_addr, wb_val, sp;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  ptr_agu u_ptr_agu (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .psel(psel),
    .mode(mode), .disp(disp), .ptr_in(ptr_in), .busy(busy), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_val(wb_val), .sp(sp));

  // {op, psel, mode, disp, ptr_in, exp_addr, exp_rd, exp_wr, exp_wben, exp_wbval}
  localparam int NV = 8;
  localparam logic [62:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 6'd0,  16'h0100, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h0000}, // R4 plain X
    {2'd1, 2'd1, 2'd1, 6'd0,  16'h0200, 16'h0200, 1'b0, 1'b1, 1'b1, 16'h0201}, // R5 post Y store
    {2'd0, 2'd2, 2'd2, 6'd0,  16'h0300, 16'h02FF, 1'b1, 1'b0, 1'b1, 16'h02FF}, // R6 pre Z
    {2'd0, 2'd2, 2'd3, 6'd2,  16'h0063, 16'h0065, 1'b1, 1'b0, 1'b0, 16'h0000}, // R7 disp Z
    {2'd1, 2'd1, 2'd3, 6'd63, 16'h1000, 16'h103F, 1'b0, 1'b1, 1'b0, 16'h0000}, // R7 max disp
    {2'd0, 2'd0, 2'd1, 6'd0,  16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h0000}, // R11 inc wrap
    {2'd1, 2'd0, 2'd2, 6'd0,  16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'hFFFF}, // R11 dec wrap
    {2'd0, 2'd1, 2'd3, 6'd63, 16'hFFF0, 16'h002F, 1'b1, 1'b0, 1'b0, 16'h0000}  // R11 disp wrap
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [1:0] p, input logic [1:0] m,
                       input logic [5:0] d, input logic [15:0] v);
    @(negedge clk);
    op = o; psel = p; mode = m; disp = d; ptr_in = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog got=hang exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] sp0;
    #1;
    @(negedge clk); @(negedge clk);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
    chk("R1 wb_en", {15'd0, wb_en}, 16'd0);
    chk("R1 sp", sp, 16'h045F);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VEC[i];
      issue(v[62:61], v[60:59], v[58:57], v[56:51], v[50:35]);
      chk("R3 busy", {15'd0, busy}, 16'd1);
      chk("R4-7 addr", mem_addr, v[34:19]);
      chk("R2 rd/wr", {14'd0, mem_rd, mem_wr}, {14'd0, v[18], v[17]});
      chk("R5/R6 wb_en", {15'd0, wb_en}, {15'd0, v[16]});
      if (v[16]) chk("R5/R6 wb_val", wb_val, v[15:0]);
      chk("R8 wb_sel", {14'd0, wb_sel}, {14'd0, v[60:59]});
      @(negedge clk);
      chk("R3 idle after", {13'd0, busy, mem_rd, mem_wr}, 16'd0);
    end

    // R8 rejections: displacement on X, pointer code 3
    issue(2'd0, 2'd0, 2'd3, 6'd5, 16'h0400);
    chk("R8 disp on X", {12'd0, busy, mem_rd, mem_wr, wb_en}, 16'd0);
    issue(2'd1, 2'd3, 2'd1, 6'd0, 16'h0400);
    chk("R8 psel 3", {12'd0, busy, mem_rd, mem_wr, wb_en}, 16'd0);

    // R9/R10 stack ordering
    sp0 = sp;
    issue(2'd2, 2'd1, 2'd3, 6'd9, 16'h1234);
    chk("R9 push addr", mem_addr, sp0);
    chk("R9 push wr", {14'd0, mem_rd, mem_wr}, 16'd1);
    chk("R9 sp after push", sp, sp0 - 16'd1);
    chk("R9 no wb", {15'd0, wb_en}, 16'd0);
    issue(2'd2, 2'd0, 2'd0, 6'd0, 16'h0000);
    chk("R9 second push addr", mem_addr, sp0 - 16'd1);
    chk("R9 sp after two", sp, sp0 - 16'd2);
    issue(2'd3, 2'd0, 2'd0, 6'd0, 16'h0000);
    chk("R10 pop addr", mem_addr, sp0 - 16'd1);
    chk("R10 pop rd", {14'd0, mem_rd, mem_wr}, 16'd2);
    chk("R10 sp after pop", sp, sp0 - 16'd1);

    // R3 start held across the access cycle is ignored
    @(negedge clk);
    op = 2'd0; psel = 2'd2; mode = 2'd1; disp = 6'd0; ptr_in = 16'h0500; start = 1'b1;
    @(negedge clk);
    chk("R3 first accepted", {15'd0, busy}, 16'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R3 held start ignored", {12'd0, busy, mem_rd, mem_wr, wb_en}, 16'd0);

    // R1 reset mid-stream restores sp
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sp reset again", sp, 16'h045F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule